// File: doc/BRIEF.md
# Hamming Syndrome Error Locator

This block sits at the end of a sector read. The parity accumulator has already produced a 24-bit code from the sector data. The copy of that code stored in flash is then read back one byte at a time and shifted into a local register. A load strobe compares the two codes by XOR, classifies the syndrome and writes a 14-bit record (a 12-bit error bit address and a 2-bit status) into one of four sector slots. The slots are used in rotation.

The controller reads the four records as eight bytes through a 3-bit address. A single flag tells the controller whether any slot holds an error worth fetching. A debug output shows the location of the most recent record.

The code layout is as follows. Pair k (for n = 2^k, k = 0..11) uses bit 2k+1 for the unprimed parity pn and bit 2k for the primed parity pn'.

Top module: `hamming_syndrome_locator`

## Requirements
- R1: On each cycle with `shift_en` high, the register shifts left by one byte and `shift_byte` enters bits 7:0. After three shifts, the first byte sits in bits 23:16 and the last in bits 7:0.
- R2: On `load_stb`, a syndrome equal to the XOR of the shifted code and `calc_code` that is all zero gives status 00 and location 0.
- R3: A syndrome in which every one of the 12 pairs is complementary (bit 2k+1 differs from bit 2k) gives status 01. The location is then {syndrome bits 23,21,...,7} as a 9-bit byte index, followed by {bits 5,3,1} as a 3-bit bit index, which equals byte*8+bit of the flipped data bit.
- R4: A syndrome with exactly one bit set is an error in the stored code alone and gives status 00 with location 0.
- R5: Every other nonzero syndrome gives status 10. Status 11 is never produced.
- R6: The location is 0 whenever the status is not 01.
- R7: Records go to slots 0,1,2,3,0,... in the order of the load strobes. The slot counter restarts at slot 0 after reset.
- R8: Readout byte 2s holds location bits 7:0 of slot s. Byte 2s+1 holds {2'b00, status[1:0], location[11:8]}. The readout byte follows `rd_addr` in the same cycle.
- R9: `err_pending` is high exactly when at least one slot holds a nonzero status.
- R10: `dbg_loc` shows the location of the most recently loaded record, from the cycle after the strobe onward.
- R11: Reset clears all records, the shift register, `dbg_loc` and the slot counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| calc_code | input | 24 | Code computed from the sector data |
| shift_en | input | 1 | Shift the stored-code byte in |
| shift_byte | input | 8 | Stored-code byte read from flash |
| load_stb | input | 1 | Evaluate the syndrome and store a record |
| rd_addr | input | 3 | Readout byte index |
| rd_byte | output | 8 | Readout byte |
| err_pending | output | 1 | Some slot holds an error |
| dbg_loc | output | 12 | Location of the latest record |

## Verification
Each shifted byte is in place at the clock edge that samples `shift_en`. A record, `dbg_loc` and `err_pending` change at the edge that samples `load_stb`, so they are due one cycle after the strobe is driven. `rd_byte` is combinational and settles in the same cycle as `rd_addr`.

The bench drives every input at the falling edge and checks each record only after the strobe edge has passed. It reads both bytes of the slot it predicts, a short delay after setting the address. The sweep covers all 4096 single-bit data locations, all 24 single-bit code errors and a spread of double errors.

// File: rtl/hamming_syndrome_locator.sv
module hamming_syndrome_locator #(
  parameter int NUM_SECT = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [23:0]                       calc_code,
  input  logic                              shift_en,
  input  logic [7:0]                        shift_byte,
  input  logic                              load_stb,
  input  logic [$clog2(NUM_SECT*2)-1:0]     rd_addr,
  output logic [7:0]                        rd_byte,
  output logic                              err_pending,
  output logic [11:0]                       dbg_loc
);
  localparam int CODE_W = 24;
  localparam int PAIRS  = CODE_W / 2;
  localparam int PTR_W  = $clog2(NUM_SECT);

  logic [CODE_W-1:0] sh;
  logic [PTR_W-1:0]  ptr;
  logic [PAIRS-1:0]  loc_q [NUM_SECT];
  logic [1:0]        st_q  [NUM_SECT];
  logic [1:0]        last_st;

  logic [CODE_W-1:0] syn;
  logic [PAIRS-1:0]  unp, new_loc;
  logic [1:0]        new_st;
  logic              compl;

  assign syn = sh ^ calc_code;

  always_comb begin
    compl = 1'b1;
    for (int k = 0; k < PAIRS; k++) begin
      unp[k] = syn[2*k+1];
      if (syn[2*k+1] == syn[2*k]) compl = 1'b0;
    end
    if (syn == '0)                 new_st = 2'b00;
    else if ($countones(syn) == 1) new_st = 2'b00;
    else if (compl)                new_st = 2'b01;
    else                           new_st = 2'b10;
    new_loc = (new_st == 2'b01) ? unp : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      ptr     <= '0;
      dbg_loc <= '0;
      last_st <= '0;
      for (int s = 0; s < NUM_SECT; s++) begin
        loc_q[s] <= '0;
        st_q[s]  <= '0;
      end
    end else begin
      if (shift_en) sh <= {sh[CODE_W-9:0], shift_byte};
      if (load_stb) begin
        loc_q[ptr] <= new_loc;
        st_q[ptr]  <= new_st;
        dbg_loc    <= new_loc;
        last_st    <= new_st;
        ptr        <= (ptr == PTR_W'(NUM_SECT-1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  logic [PTR_W-1:0] sel;
  assign sel     = rd_addr[PTR_W:1];
  assign rd_byte = rd_addr[0] ? {2'b00, st_q[sel], loc_q[sel][11:8]} : loc_q[sel][7:0];

  always_comb begin
    err_pending = 1'b0;
    for (int s = 0; s < NUM_SECT; s++)
      if (st_q[s] != 2'b00) err_pending = 1'b1;
  end

  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sh[7:0] == $past(shift_byte));
  a_r2_clean_record: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && sh == calc_code) |=> (last_st == 2'b00 && dbg_loc == '0));
  a_r5_no_status11: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> last_st != 2'b11);
  a_r6_loc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (last_st != 2'b01) |-> dbg_loc == '0);
  a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> ptr == (($past(ptr) == PTR_W'(NUM_SECT-1)) ? '0 : $past(ptr) + 1'b1));
  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr[0] |-> (rd_byte[7:6] == 2'b00 && rd_byte[5:4] != 2'b11));
  a_r9_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_stb) && $past(err_pending)) |-> err_pending);
endmodule

// File: tb/hamming_syndrome_locator_tb_top.sv
module hamming_syndrome_locator_tb_top;
  logic clk = 0, rst_n = 0;
  logic [23:0] calc_code = 0;
  logic shift_en = 0, load_stb = 0;
  logic [7:0] shift_byte = 0;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_byte;
  logic err_pending;
  logic [11:0] dbg_loc;

  int n_chk = 0, n_fail = 0, slot = 0, cyc = 0;
  logic [1:0] exp_st [4];

  always #10 clk = ~clk;

  hamming_syndrome_locator dut_i (
    .clk(clk), .rst_n(rst_n), .calc_code(calc_code), .shift_en(shift_en),
    .shift_byte(shift_byte), .load_stb(load_stb), .rd_addr(rd_addr),
    .rd_byte(rd_byte), .err_pending(err_pending), .dbg_loc(dbg_loc));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] loc_syn(int loc);
    logic [23:0] s = '0;
    for (int k = 0; k < 12; k++)
      if ((loc >> k) & 1) s[2*k+1] = 1'b1; else s[2*k] = 1'b1;
    return s;
  endfunction

  task automatic run(logic [23:0] calc, logic [23:0] syn, logic [1:0] est, logic [11:0] eloc, string req);
    logic [23:0] stored = calc ^ syn;
    @(negedge clk); shift_en = 1; shift_byte = stored[23:16];
    @(negedge clk); shift_byte = stored[15:8];
    @(negedge clk); shift_byte = stored[7:0];
    @(negedge clk); shift_en = 0; load_stb = 1; calc_code = calc;
    @(negedge clk); load_stb = 0;
    exp_st[slot] = est;
    rd_addr = 3'(2*slot); #1;
    chk({req, " low byte"}, rd_byte, eloc[7:0]);
    rd_addr = 3'(2*slot+1); #1;
    chk({req, " high byte R8"}, rd_byte, {2'b00, est, eloc[11:8]});
    chk("R10 dbg_loc", dbg_loc, eloc);
    chk("R9 err_pending", err_pending,
        (exp_st[0] != 0) || (exp_st[1] != 0) || (exp_st[2] != 0) || (exp_st[3] != 0));
    slot = (slot + 1) % 4;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_up();
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) exp_st[s] = 0;
    #35 rst_n = 1;
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R11 reset record", rd_byte, 0);
    end
    chk("R11 reset flag", err_pending, 0);
    chk("R11 reset dbg", dbg_loc, 0);
    // R2 zero syndrome
    run(24'h5A3C96, 24'h0, 2'b00, 12'h0, "R2 clean");
    // R3 every single data bit location, R1 byte order via stored value
    for (int loc = 0; loc < 4096; loc++)
      run(24'(loc * 24'h1F3 + 24'hA5), loc_syn(loc), 2'b01, 12'(loc), "R3 single");
    // R4 code-only errors
    for (int b = 0; b < 24; b++)
      run(24'(b * 24'h3377), 24'(1) << b, 2'b00, 12'h0, "R4 code-only");
    // R5/R6 double errors
    for (int a = 0; a < 4096; a += 37) begin
      int b = (a * 7 + 5) % 4096;
      if (b == a) b = (a + 1) % 4096;
      run(24'(a), loc_syn(a) ^ loc_syn(b), 2'b10, 12'h0, "R5 R6 double");
    end
    // R7: fill all slots with clean, then reset returns slot to 0
    for (int i = 0; i < 4; i++) run(24'h0, 24'h0, 2'b00, 12'h0, "R7 clear");
    run(24'h0, loc_syn(9), 2'b01, 12'd9, "R7 slot");
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    slot = 0;
    for (int s = 0; s < 4; s++) exp_st[s] = 0;
    run(24'h0, loc_syn(300), 2'b01, 12'd300, "R7 after reset");
    rd_addr = 3'd2; #1; chk("R7 slot1 untouched", rd_byte, 0);
    finish_up();
  end
endmodule